// File: doc/BRIEF.md
# DMA Operand Packing Transfer Sequencer

This block runs the bus cycles that move a block of bytes from a source pointer to a destination pointer, one operand at a time, as a bus master on a simple request/acknowledge interface. It is set up once per run: the width of the system bus (8 or 16 bits), the size of each side (byte or word), an increment enable for each pointer, the two start pointers and a byte count. A start pulse samples all of these. The block then reads and writes until the count reaches zero, and pulses done.

On a 16-bit bus it packs two byte reads into one word write, or unpacks one word read into two byte writes. A byte-sized side next to a word-sized side is treated as an 8-bit peripheral on one half of the bus, so its successive bytes sit two addresses apart. A word access at an odd address is split into two byte cycles. The current pointers and the remaining count are visible at the ports, so a controller around the block can see where the run stopped.

Byte data travels on bus lanes [7:0] in both directions. For a byte write the upper lane is driven with zero, and for a byte read the upper lane is ignored. Word data is big-endian: bits [15:8] hold the byte at the lower address.

Top module: `dma_pk_seq`

## Requirements
- R1: With `wide_i`=0 (8-bit bus) the size inputs are ignored. Each operand is one byte read at the source pointer followed by one byte write at the destination pointer, the count drops by 1 and each enabled pointer advances by 1.
- R2: With `wide_i`=1 and both sizes byte (`src_word_i`=`dst_word_i`=0), each operand is one byte read followed by one byte write, and each enabled pointer advances by 1.
- R3: With `wide_i`=1, a byte source and a word destination, the block reads bytes at S and S+2 and then writes one word at D. The first byte read goes to bits [15:8] of that word. The source advances by 4, the destination by 2 and the count by 2.
- R4: With `wide_i`=1, a word source and a byte destination, the block reads one word at S and then writes bits [15:8] at D and bits [7:0] at D+2. The source advances by 2, the destination by 4 and the count by 2.
- R5: With `wide_i`=1 and both sizes word, each operand is one word read and one word write, and each enabled pointer advances by 2.
- R6: A word access at an odd address A becomes two byte cycles, at A and then A+1, with the upper byte first. No bus cycle with `bus_word_o`=1 ever carries an odd address. If both pointers are odd in word/word mode, one operand takes four bus cycles.
- R7: A pointer whose increment enable is 0 keeps its value for the whole run, and all of its cycles use that same address.
- R8: On a 16-bit bus, when the count is 1 and either side is word-sized, the operand is one byte read and one byte write, and the count drops to 0. A byte side paired with a word side advances by 2. A word side advances by 1.
- R9: While `bus_req_o` is high and `bus_ack_i` is low, the request, direction, size, address and write data all stay unchanged on the next cycle.
- R10: `done_o` is high for exactly one cycle, the cycle after the final write is acknowledged, and `bus_req_o` is low while it is high. A start with count 0 gives `done_o` on the next cycle and no bus cycle at all.
- R11: After reset, `bus_req_o`, `done_o` and `busy_o` are 0. `bus_req_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Samples the setup and begins a run while idle |
| wide_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| src_word_i | input | 1 | Source size, 1 = word |
| dst_word_i | input | 1 | Destination size, 1 = word |
| src_inc_i | input | 1 | Source pointer advance enable |
| dst_inc_i | input | 1 | Destination pointer advance enable |
| src_ptr_i | input | AW | Start source address |
| dst_ptr_i | input | AW | Start destination address |
| count_i | input | CW | Bytes to move |
| bus_req_o | output | 1 | Bus cycle request |
| bus_wr_o | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word_o | output | 1 | 1 = word cycle, 0 = byte cycle |
| bus_addr_o | output | AW | Cycle address |
| bus_wdata_o | output | 16 | Write data |
| bus_ack_i | input | 1 | Cycle completes at this edge |
| bus_rdata_i | input | 16 | Read data, valid with acknowledge |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| src_ptr_o | output | AW | Current source pointer |
| dst_ptr_o | output | AW | Current destination pointer |
| count_o | output | CW | Bytes still to move |

## Verification
The bench builds the block with AW=16 and CW=8. The 16-bit address width makes it cheap to start a word run at 0xFFFE and watch the source pointer wrap to 0x0000 partway through the run. The 8-bit count keeps the odd-count tails that reach the single-byte path inside short runs. The bench varies the acknowledge delay from zero to two wait cycles, so every cycle shape is held across a stall at least once.

// File: rtl/dma_pk_pkg.sv
package dma_pk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } state_e;

    // How one side (source or destination) is accessed for the current operand
    typedef struct packed {
        logic       two;     // two bus cycles on this side
        logic       word;    // cycles are word sized
        logic [1:0] stride;  // address distance between the two cycles
        logic [2:0] inc;     // pointer advance once the operand completes
    } plan_t;

endpackage

// File: rtl/dma_pk_side_plan.sv
module dma_pk_side_plan
    import dma_pk_pkg::*;
(
    input  logic  wide_i,
    input  logic  self_word_i,
    input  logic  other_word_i,
    input  logic  single_i,
    input  logic  base_odd_i,
    output plan_t plan_o
);
    always_comb begin
        plan_o        = '0;
        plan_o.stride = 2'd1;
        plan_o.inc    = 3'd1;
        if (!wide_i) begin
            // narrow bus: one byte per side, step one
            plan_o.two  = 1'b0;
            plan_o.word = 1'b0;
        end else if (single_i || (!self_word_i && !other_word_i)) begin
            // one byte moves; a byte side facing a word side sits on a half bus
            plan_o.two = 1'b0;
            plan_o.inc = (!self_word_i && other_word_i) ? 3'd2 : 3'd1;
        end else if (self_word_i) begin
            plan_o.inc = 3'd2;
            if (base_odd_i) begin
                plan_o.two    = 1'b1;
                plan_o.stride = 2'd1;
            end else begin
                plan_o.word = 1'b1;
            end
        end else begin
            // byte side packing against a word side: half-bus peripheral
            plan_o.two    = 1'b1;
            plan_o.stride = 2'd2;
            plan_o.inc    = 3'd4;
        end
    end
endmodule

// File: rtl/dma_pk_lane.sv
module dma_pk_lane (
    input  logic        rd_word_i,
    input  logic        rd_two_i,
    input  logic        wr_word_i,
    input  logic        wr_two_i,
    input  logic        idx_i,
    input  logic [15:0] rdata_i,
    input  logic [15:0] hold_i,
    output logic [15:0] hold_o,
    output logic [15:0] wdata_o
);
    always_comb begin
        if (rd_word_i) begin
            hold_o = rdata_i;
        end else if (rd_two_i) begin
            hold_o = idx_i ? {hold_i[15:8], rdata_i[7:0]} : {rdata_i[7:0], hold_i[7:0]};
        end else begin
            hold_o = {8'h00, rdata_i[7:0]};
        end
    end

    always_comb begin
        if (wr_word_i) begin
            wdata_o = hold_i;
        end else if (wr_two_i && !idx_i) begin
            wdata_o = {8'h00, hold_i[15:8]};
        end else begin
            wdata_o = {8'h00, hold_i[7:0]};
        end
    end
endmodule

// File: rtl/dma_pk_seq.sv
module dma_pk_seq
    import dma_pk_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wide_i,
    input  logic          src_word_i,
    input  logic          dst_word_i,
    input  logic          src_inc_i,
    input  logic          dst_inc_i,
    input  logic [AW-1:0] src_ptr_i,
    input  logic [AW-1:0] dst_ptr_i,
    input  logic [CW-1:0] count_i,
    output logic          bus_req_o,
    output logic          bus_wr_o,
    output logic          bus_word_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [15:0]   bus_wdata_o,
    input  logic          bus_ack_i,
    input  logic [15:0]   bus_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] src_ptr_o,
    output logic [AW-1:0] dst_ptr_o,
    output logic [CW-1:0] count_o
);
    localparam int SIDES = 2;

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic          idx;
        logic [15:0]   hold;
        logic          wide;
        logic          sw;
        logic          dw;
        logic          sinc;
        logic          dinc;
    } regs_t;

    regs_t r_q, r_d;

    plan_t            plan [SIDES];
    logic [SIDES-1:0] self_w, other_w, base_odd;
    logic             single;
    logic             op_two;
    logic [15:0]      hold_next;
    logic [15:0]      wdata;
    logic [AW-1:0]    offs;

    assign single   = (r_q.cnt == CW'(1));
    assign self_w   = {r_q.dw, r_q.sw};
    assign other_w  = {r_q.sw, r_q.dw};
    assign base_odd = {r_q.dst[0], r_q.src[0]};
    assign op_two   = r_q.wide && !single && (r_q.sw || r_q.dw);

    // index 0 plans the source side, index 1 the destination side
    generate
        for (genvar g = 0; g < SIDES; g++) begin : g_side
            dma_pk_side_plan u_plan (
                .wide_i      (r_q.wide),
                .self_word_i (self_w[g]),
                .other_word_i(other_w[g]),
                .single_i    (single),
                .base_odd_i  (base_odd[g]),
                .plan_o      (plan[g])
            );
        end
    endgenerate

    dma_pk_lane u_lane (
        .rd_word_i(plan[0].word),
        .rd_two_i (plan[0].two),
        .wr_word_i(plan[1].word),
        .wr_two_i (plan[1].two),
        .idx_i    (r_q.idx),
        .rdata_i  (bus_rdata_i),
        .hold_i   (r_q.hold),
        .hold_o   (hold_next),
        .wdata_o  (wdata)
    );

    // bus outputs depend on registered state only, so they hold until acknowledge
    always_comb begin
        bus_req_o   = 1'b0;
        bus_wr_o    = 1'b0;
        bus_word_o  = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        offs        = '0;
        case (r_q.st)
            ST_READ: begin
                offs       = r_q.idx ? AW'(plan[0].stride) : '0;
                bus_req_o  = 1'b1;
                bus_word_o = plan[0].word;
                bus_addr_o = r_q.src + offs;
            end
            ST_WRITE: begin
                offs        = r_q.idx ? AW'(plan[1].stride) : '0;
                bus_req_o   = 1'b1;
                bus_wr_o    = 1'b1;
                bus_word_o  = plan[1].word;
                bus_addr_o  = r_q.dst + offs;
                bus_wdata_o = wdata;
            end
            default: ;
        endcase
    end

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.src  = src_ptr_i;
                    r_d.dst  = dst_ptr_i;
                    r_d.cnt  = count_i;
                    r_d.wide = wide_i;
                    r_d.sw   = src_word_i;
                    r_d.dw   = dst_word_i;
                    r_d.sinc = src_inc_i;
                    r_d.dinc = dst_inc_i;
                    r_d.idx  = 1'b0;
                    r_d.hold = '0;
                    r_d.st   = (count_i == '0) ? ST_FIN : ST_READ;
                end
            end
            ST_READ: begin
                if (bus_ack_i) begin
                    r_d.hold = hold_next;
                    if (plan[0].two && !r_q.idx) begin
                        r_d.idx = 1'b1;
                    end else begin
                        r_d.idx = 1'b0;
                        r_d.st  = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (bus_ack_i) begin
                    if (plan[1].two && !r_q.idx) begin
                        r_d.idx = 1'b1;
                    end else begin
                        r_d.idx = 1'b0;
                        if (r_q.sinc) r_d.src = r_q.src + AW'(plan[0].inc);
                        if (r_q.dinc) r_d.dst = r_q.dst + AW'(plan[1].inc);
                        r_d.cnt = r_q.cnt - (op_two ? CW'(2) : CW'(1));
                        r_d.st  = (r_d.cnt == '0) ? ST_FIN : ST_READ;
                    end
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = (r_q.st == ST_FIN);
    assign src_ptr_o = r_q.src;
    assign dst_ptr_o = r_q.dst;
    assign count_o   = r_q.cnt;

endmodule

// File: rtl/dma_pk_seq_chk.sv
module dma_pk_seq_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req_o,
    input logic          bus_wr_o,
    input logic          bus_word_o,
    input logic [AW-1:0] bus_addr_o,
    input logic [15:0]   bus_wdata_o,
    input logic          bus_ack_i,
    input logic          busy_o,
    input logic          done_o
);
    assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_wr_o) && $stable(bus_word_o)
                                       && $stable(bus_addr_o) && $stable(bus_wdata_o)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !bus_req_o);

    assert_word_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_word_o) |-> !bus_addr_o[0]);

    assert_req_needs_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o);
endmodule

bind dma_pk_seq dma_pk_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req_o  (bus_req_o),
    .bus_wr_o   (bus_wr_o),
    .bus_word_o (bus_word_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_ack_i  (bus_ack_i),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/dma_pk_seq_test.sv
module dma_pk_seq_test;
    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wide_i = 1'b0, src_word_i = 1'b0, dst_word_i = 1'b0;
    logic          src_inc_i = 1'b0, dst_inc_i = 1'b0;
    logic [AW-1:0] src_ptr_i = '0, dst_ptr_i = '0;
    logic [CW-1:0] count_i = '0;
    logic          bus_req_o, bus_wr_o, bus_word_o;
    logic [AW-1:0] bus_addr_o;
    logic [15:0]   bus_wdata_o;
    logic          bus_ack_i = 1'b0;
    logic [15:0]   bus_rdata_i = '0;
    logic          busy_o, done_o;
    logic [AW-1:0] src_ptr_o, dst_ptr_o;
    logic [CW-1:0] count_o;

    int n_checks = 0;
    int n_fail   = 0;
    int pat      = 0;

    always #2 clk = ~clk;   // 4 ns period

    dma_pk_seq #(.AW(AW), .CW(CW)) uut (.*);

    typedef struct {
        bit          wr;
        bit          word;
        logic [15:0] addr;
        logic [15:0] data;
    } op_t;

    op_t exp_q[$];

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void push(bit wr, bit word, logic [15:0] a, logic [15:0] d);
        op_t o;
        o.wr = wr; o.word = word; o.addr = a; o.data = d;
        exp_q.push_back(o);
    endfunction

    // word-sized side: even address is one word cycle, odd is two byte cycles
    function automatic logic [15:0] word_side(bit wr, logic [15:0] a, logic [15:0] v);
        logic [15:0] r;
        if (a[0]) begin
            r = {mem_byte(a), mem_byte(a + 16'd1)};
            if (wr) begin
                push(1, 0, a, {8'h00, v[15:8]});
                push(1, 0, a + 16'd1, {8'h00, v[7:0]});
            end else begin
                push(0, 0, a, 16'h0);
                push(0, 0, a + 16'd1, 16'h0);
            end
        end else begin
            r = {mem_byte(a), mem_byte(a + 16'd1)};
            push(wr, 1, a, wr ? v : 16'h0);
        end
        return r;
    endfunction

    task automatic run_case(string req, bit wide, bit sw, bit dw, bit si, bit di,
                            logic [15:0] sp, logic [15:0] dp, int cnt);
        logic [15:0] s, d, v;
        int          c, wait_cnt, ndone;
        bit          fin;
        s = sp; d = dp; c = cnt;
        exp_q.delete();
        while (c > 0) begin
            if (!wide || (!sw && !dw)) begin
                push(0, 0, s, 0);
                push(1, 0, d, {8'h00, mem_byte(s)});
                if (si) s = s + 16'd1;
                if (di) d = d + 16'd1;
                c = c - 1;
            end else if (c == 1) begin
                push(0, 0, s, 0);
                push(1, 0, d, {8'h00, mem_byte(s)});
                if (si) s = s + (sw ? 16'd1 : 16'd2);
                if (di) d = d + (dw ? 16'd1 : 16'd2);
                c = 0;
            end else if (sw && dw) begin
                v = word_side(0, s, 0);
                void'(word_side(1, d, v));
                if (si) s = s + 16'd2;
                if (di) d = d + 16'd2;
                c = c - 2;
            end else if (dw) begin
                push(0, 0, s, 0);
                push(0, 0, s + 16'd2, 0);
                v = {mem_byte(s), mem_byte(s + 16'd2)};
                void'(word_side(1, d, v));
                if (si) s = s + 16'd4;
                if (di) d = d + 16'd2;
                c = c - 2;
            end else begin
                v = word_side(0, s, 0);
                push(1, 0, d, {8'h00, v[15:8]});
                push(1, 0, d + 16'd2, {8'h00, v[7:0]});
                if (si) s = s + 16'd2;
                if (di) d = d + 16'd4;
                c = c - 2;
            end
        end

        @(negedge clk);
        wide_i = wide; src_word_i = sw; dst_word_i = dw;
        src_inc_i = si; dst_inc_i = di;
        src_ptr_i = sp; dst_ptr_i = dp; count_i = CW'(cnt);
        start = 1'b1;
        fin = 0; ndone = 0; wait_cnt = 0;
        for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            bus_ack_i = 1'b0;
            if (done_o) begin
                fin = 1;
                chk(exp_q.size() == 0, req, "cycles left at done", exp_q.size(), 0);
                chk(src_ptr_o == s, req, "final source pointer", src_ptr_o, s);
                chk(dst_ptr_o == d, req, "final destination pointer", dst_ptr_o, d);
                chk(count_o == 0, req, "final count", count_o, 0);
                chk(!bus_req_o, "R10", "request during done", bus_req_o, 0);
            end else if (bus_req_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, req, "unexpected bus cycle", bus_addr_o, 0);
                end else begin
                    op_t e;
                    e = exp_q[0];
                    chk(bus_wr_o == e.wr && bus_word_o == e.word && bus_addr_o == e.addr,
                        req, "cycle wr/word/addr", {bus_wr_o, bus_word_o, 14'h0, bus_addr_o},
                        {e.wr, e.word, 14'h0, e.addr});
                    if (e.wr)
                        chk(bus_wdata_o == e.data, req, "write data", bus_wdata_o, e.data);
                    if (wait_cnt == 0) begin
                        bus_ack_i = 1'b1;
                        bus_rdata_i = e.word ? {mem_byte(e.addr), mem_byte(e.addr + 16'd1)}
                                             : {8'hEE, mem_byte(e.addr)};
                        void'(exp_q.pop_front());
                        pat++;
                        wait_cnt = pat % 3;
                    end else begin
                        wait_cnt--;
                    end
                end
            end
        end
        if (!fin) chk(0, req, "watchdog expired, no done", 0, 1);
        @(negedge clk);
        bus_ack_i = 1'b0;
        chk(!done_o && !busy_o, "R10", "done lasts one cycle", {done_o, busy_o}, 0);
        ndone = ndone;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_req_o && !done_o && !busy_o, "R11", "reset state",
            {bus_req_o, done_o, busy_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req_o && !busy_o, "R11", "idle after reset", {bus_req_o, busy_o}, 0);

        run_case("R1",  0, 1, 1, 1, 1, 16'h0100, 16'h0201, 3);
        run_case("R2",  1, 0, 0, 1, 1, 16'h0301, 16'h0400, 3);
        run_case("R3",  1, 0, 1, 1, 1, 16'h0500, 16'h0600, 4);
        run_case("R4",  1, 1, 0, 1, 1, 16'h0700, 16'h0800, 4);
        run_case("R5",  1, 1, 1, 1, 1, 16'h0900, 16'h0A00, 4);
        run_case("R6",  1, 1, 1, 1, 1, 16'h0B01, 16'h0C03, 2);
        run_case("R6",  1, 0, 1, 1, 1, 16'h0D00, 16'h0E01, 2);
        run_case("R8",  1, 0, 1, 1, 1, 16'h0F00, 16'h1000, 3);
        run_case("R8",  1, 1, 1, 1, 1, 16'h1100, 16'h1200, 1);
        run_case("R8",  1, 1, 0, 1, 1, 16'h1300, 16'h1400, 1);
        run_case("R7",  1, 1, 0, 0, 1, 16'h1500, 16'h1600, 4);
        run_case("R7",  1, 0, 1, 1, 0, 16'h1700, 16'h1800, 4);
        run_case("R5",  1, 1, 1, 1, 1, 16'hFFFE, 16'h0010, 4);
        run_case("R10", 1, 1, 1, 1, 1, 16'h2000, 16'h2100, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule